// File: doc/BRIEF.md
# Packet receive stream controller

This block takes packets from a valid/ready stream (32-bit data word, 4-bit byte-keep, 4-bit destination, end-of-packet marker) and parks them in a word store. For each packet it also queues a small record holding the byte count and the destination. Software drains packets through a read port with a one-cycle read latency. A read of the length address pops the next packet record and opens that packet for data reads. Data words then leave the store in arrival order. The block also reports events: a packet has landed, bad reads, threshold crossings of the fill level, and completion of a receive-side flush.

The word count that software sees grows only when the final beat of a packet is accepted. A non-zero value therefore always means that at least one whole packet is waiting. A flush request does not cut into a packet in flight. It waits until the current packet has ended, then clears the store, the record queue and the per-packet read state in one cycle.

Back-pressure rules: a beat transfers on a rising clock edge where both `s_valid` and `s_ready` are high. `s_ready` depends only on internal state and never on `s_valid`. A sender is expected to deliver each packet without gaps once it has started, and to keep a stalled beat on the bus until it is taken.

Top module: `rx_pkt_ctrl`

## Requirements
- R1: Reading address 0x1C returns, in bits 11..0, the number of words of fully received packets that have not yet been read. That count rises only at the clock edge that accepts a beat with `s_last` high, and then by the packet's whole word count.
- R2: Reading address 0x20 while that count is non-zero returns the oldest stored word, one cycle after `rd_en`, and removes it. Words leave in the order they arrived.
- R3: Reading address 0x24 returns in bits 13..0 the byte length of the oldest unread packet and pops its record. The byte length is the total of set `s_keep` bits over all beats of the packet, up to and including the last beat.
- R4: Reading address 0x30 returns in bits 3..0 the destination (the `s_dest` value on the last beat) of the packet whose length was read most recently. It returns 0 after reset and after a flush.
- R5: `ev_rx_done` pulses for one cycle in the cycle after a last beat is accepted, and at no other time.
- R6: A data read while the R1 count is zero pulses `ev_data_underrun` in the next cycle and returns 0. It removes nothing from the store.
- R7: A data read that finds a stored word after the opened packet's words are used up still returns and removes that word, and pulses `ev_over_read` in the next cycle.
- R8: A length read with no queued packet record pulses `ev_len_underrun` in the next cycle and returns 0.
- R9: `s_ready` is low whenever the store holds DEPTH words, or the record queue holds META_DEPTH records, or a flush is waiting outside a packet. A beat offered while `s_ready` is low is not stored.
- R10: A `flush_req` pulse is held pending while a packet is partly received. In the first cycle where it is pending outside a packet, the store, the record queue, the open-packet state and the destination are cleared, and `ev_flush_done` pulses in the next cycle. A read issued in that flush cycle returns 0 and has no effect.
- R11: `ev_prog_full` pulses when the total stored word count (including words of a packet still arriving) moves from below PF_THRESH to PF_THRESH or more. `ev_prog_empty` pulses when it moves from above PE_THRESH to PE_THRESH or less.
- R12: `rd_data` is 0 in any cycle after a cycle without `rd_en`, and after a read of any address other than 0x1C, 0x20, 0x24 or 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Ingress beat valid |
| s_ready | output | 1 | Ingress beat accepted when high with s_valid |
| s_data | input | 32 | Ingress data word |
| s_keep | input | 4 | Ingress byte-keep, one bit per byte |
| s_dest | input | 4 | Ingress destination, taken on the last beat |
| s_last | input | 1 | Marks the final beat of a packet |
| rd_en | input | 1 | Read strobe for the software port |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read result, valid the cycle after rd_en |
| flush_req | input | 1 | Pulse requesting a deferred receive flush |
| ev_rx_done | output | 1 | Packet fully received |
| ev_data_underrun | output | 1 | Data read with nothing committed |
| ev_over_read | output | 1 | Data read past the opened packet |
| ev_len_underrun | output | 1 | Length read with no record queued |
| ev_prog_full | output | 1 | Fill level reached the upper threshold |
| ev_prog_empty | output | 1 | Fill level reached the lower threshold |
| ev_flush_done | output | 1 | Flush has been carried out |

## Verification
A stale commit count shows up at the very next occupancy read as a non-zero value in the middle of a packet. It also shows up as a data read that returns a word instead of raising the underrun event. A wrong open-packet word counter shows up only when the next packet is read: the over-read event appears one word early or late. A dropped record pop shows as a repeated length on the following length read. The bench compares every output against a behavioural model on every clock, so any such slip is reported in the cycle it reaches a port.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;

  localparam int DATA_W      = 32;
  localparam int KEEP_W      = DATA_W / 8;
  localparam int DEST_W      = 4;
  localparam int LEN_FIELD_W = 14;
  localparam int ADDR_W      = 8;

  // read-port byte addresses
  localparam logic [ADDR_W-1:0] A_FILL = 8'h1C;
  localparam logic [ADDR_W-1:0] A_WORD = 8'h20;
  localparam logic [ADDR_W-1:0] A_SIZE = 8'h24;
  localparam logic [ADDR_W-1:0] A_DST  = 8'h30;

  // one record per landed packet
  typedef struct packed {
    logic [LEN_FIELD_W-1:0] bytes;
    logic [DEST_W-1:0]      dest;
    logic [LEN_FIELD_W-1:0] words;
  } pkt_meta_t;

  function automatic logic [LEN_FIELD_W-1:0] keep_bytes(input logic [KEEP_W-1:0] k);
    logic [LEN_FIELD_W-1:0] n;
    n = '0;
    for (int i = 0; i < KEEP_W; i++) n = n + LEN_FIELD_W'(k[i]);
    return n;
  endfunction

endpackage

// File: rtl/rx_word_store.sv
module rx_word_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int LVL_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              commit,
  input  logic [LVL_W-1:0]  commit_words,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_nxt,
  output logic [LVL_W-1:0]  committed
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  committed_nxt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];

  always_comb begin
    if (flush) begin
      level_nxt     = '0;
      committed_nxt = '0;
    end else begin
      level_nxt     = level + LVL_W'(push) - LVL_W'(pop);
      committed_nxt = committed + (commit ? commit_words : '0) - LVL_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level     <= '0;
      committed <= '0;
    end else begin
      level     <= level_nxt;
      committed <= committed_nxt;
    end
  end

endmodule

// File: rtl/rx_meta_fifo.sv
module rx_meta_fifo import rx_pkt_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  pkt_meta_t        din,
  input  logic             pop,
  output pkt_meta_t        head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pkt_meta_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/rx_level_watch.sv
module rx_level_watch #(
  parameter int LVL_W     = 10,
  parameter int PF_THRESH = 510,
  parameter int PE_THRESH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_nxt,
  output logic             ev_prog_full,
  output logic             ev_prog_empty
);
  logic hi_now, hi_nxt, lo_now, lo_nxt;

  assign hi_now = int'(level)     >= PF_THRESH;
  assign hi_nxt = int'(level_nxt) >= PF_THRESH;
  assign lo_now = int'(level)     <= PE_THRESH;
  assign lo_nxt = int'(level_nxt) <= PE_THRESH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_prog_full  <= 1'b0;
      ev_prog_empty <= 1'b0;
    end else begin
      ev_prog_full  <= hi_nxt && !hi_now;
      ev_prog_empty <= lo_nxt && !lo_now;
    end
  end

endmodule

// File: rtl/rx_pkt_ctrl.sv
module rx_pkt_ctrl import rx_pkt_pkg::*; #(
  parameter int DEPTH      = 512,
  parameter int META_DEPTH = 16,
  parameter int PF_THRESH  = 510,
  parameter int PE_THRESH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [KEEP_W-1:0] s_keep,
  input  logic [DEST_W-1:0] s_dest,
  input  logic              s_last,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flush_req,
  output logic              ev_rx_done,
  output logic              ev_data_underrun,
  output logic              ev_over_read,
  output logic              ev_len_underrun,
  output logic              ev_prog_full,
  output logic              ev_prog_empty,
  output logic              ev_flush_done
);
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam int MCW   = $clog2(META_DEPTH) + 1;

  // ingress accumulation
  logic                   in_pkt;
  logic [LEN_FIELD_W-1:0] acc_bytes;
  logic [LVL_W-1:0]       acc_words;
  // open-packet read state
  logic [LEN_FIELD_W-1:0] cur_left;
  logic [DEST_W-1:0]      cur_dest;
  logic                   flush_pending;
  logic                   flush_now;

  logic             beat, commit;
  logic [LVL_W-1:0] level, level_nxt, committed, commit_words;
  logic [DATA_W-1:0] pop_data;
  pkt_meta_t        meta_in, meta_head;
  logic [MCW-1:0]   meta_count;
  logic             meta_empty, meta_full;

  logic rd_ok, rd_fill, rd_word, rd_size, rd_dst;
  logic data_pop, meta_pop, have_words;
  logic [DATA_W-1:0] rd_nxt;

  assign flush_now = flush_pending && !in_pkt;
  assign s_ready   = (level < LVL_W'(DEPTH)) && !meta_full && !flush_now;
  assign beat      = s_valid && s_ready;
  assign commit    = beat && s_last;

  assign commit_words  = acc_words + 1'b1;
  assign meta_in.bytes = acc_bytes + keep_bytes(s_keep);
  assign meta_in.dest  = s_dest;
  assign meta_in.words = LEN_FIELD_W'(commit_words);

  // read decode
  assign rd_ok      = rd_en && !flush_now;
  assign rd_fill    = rd_ok && (rd_addr == A_FILL);
  assign rd_word    = rd_ok && (rd_addr == A_WORD);
  assign rd_size    = rd_ok && (rd_addr == A_SIZE);
  assign rd_dst     = rd_ok && (rd_addr == A_DST);
  assign have_words = (committed != '0);
  assign data_pop   = rd_word && have_words;
  assign meta_pop   = rd_size && !meta_empty;

  always_comb begin
    rd_nxt = '0;
    if (rd_fill)       rd_nxt = DATA_W'(committed);
    else if (data_pop) rd_nxt = pop_data;
    else if (meta_pop) rd_nxt = DATA_W'(meta_head.bytes);
    else if (rd_dst)   rd_nxt = DATA_W'(cur_dest);
  end

  rx_word_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush_now),
    .push         (beat),
    .push_data    (s_data),
    .commit       (commit),
    .commit_words (commit_words),
    .pop          (data_pop),
    .pop_data     (pop_data),
    .level        (level),
    .level_nxt    (level_nxt),
    .committed    (committed)
  );

  rx_meta_fifo #(.DEPTH(META_DEPTH), .CNT_W(MCW)) u_meta (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_now),
    .push  (commit),
    .din   (meta_in),
    .pop   (meta_pop),
    .head  (meta_head),
    .count (meta_count),
    .empty (meta_empty),
    .full  (meta_full)
  );

  rx_level_watch #(.LVL_W(LVL_W), .PF_THRESH(PF_THRESH), .PE_THRESH(PE_THRESH)) u_watch (
    .clk           (clk),
    .rst_n         (rst_n),
    .level         (level),
    .level_nxt     (level_nxt),
    .ev_prog_full  (ev_prog_full),
    .ev_prog_empty (ev_prog_empty)
  );

  // ingress packet tracking and flush deferral
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt        <= 1'b0;
      acc_bytes     <= '0;
      acc_words     <= '0;
      flush_pending <= 1'b0;
    end else if (flush_now) begin
      in_pkt        <= 1'b0;
      acc_bytes     <= '0;
      acc_words     <= '0;
      flush_pending <= 1'b0;
    end else begin
      if (flush_req) flush_pending <= 1'b1;
      if (commit) begin
        in_pkt    <= 1'b0;
        acc_bytes <= '0;
        acc_words <= '0;
      end else if (beat) begin
        in_pkt    <= 1'b1;
        acc_bytes <= meta_in.bytes;
        acc_words <= commit_words;
      end
    end
  end

  // open-packet read state
  always_ff @(posedge clk) begin
    if (!rst_n || flush_now) begin
      cur_left <= '0;
      cur_dest <= '0;
    end else if (meta_pop) begin
      cur_left <= meta_head.words;
      cur_dest <= meta_head.dest;
    end else if (data_pop && cur_left != '0) begin
      cur_left <= cur_left - 1'b1;
    end
  end

  // read result and event pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data          <= '0;
      ev_rx_done       <= 1'b0;
      ev_data_underrun <= 1'b0;
      ev_over_read     <= 1'b0;
      ev_len_underrun  <= 1'b0;
      ev_flush_done    <= 1'b0;
    end else begin
      rd_data          <= rd_nxt;
      ev_rx_done       <= commit;
      ev_data_underrun <= rd_word && !have_words;
      ev_over_read     <= data_pop && (cur_left == '0);
      ev_len_underrun  <= rd_size && meta_empty;
      ev_flush_done    <= flush_now;
    end
  end

endmodule

// File: rtl/rx_pkt_ctrl_chk.sv
module rx_pkt_ctrl_chk #(
  parameter int DEPTH = 512,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_last,
  input logic [31:0]      rd_data,
  input logic             ev_rx_done,
  input logic             ev_data_underrun,
  input logic             ev_len_underrun,
  input logic             ev_flush_done,
  input logic             flush_pending,
  input logic             in_pkt,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] committed
);

  AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (committed > $past(committed)) |-> $past(s_valid && s_ready && s_last)); // R1

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> ev_rx_done); // R5

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_underrun |-> (rd_data == '0)); // R6

  AST_LEN_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_len_underrun |-> (rd_data == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R9

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !s_ready); // R9

  AST_FLUSH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pending && in_pkt) |=> !ev_flush_done); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_done |-> (level == '0 && committed == '0)); // R10

endmodule

bind rx_pkt_ctrl rx_pkt_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .s_valid          (s_valid),
  .s_ready          (s_ready),
  .s_last           (s_last),
  .rd_data          (rd_data),
  .ev_rx_done       (ev_rx_done),
  .ev_data_underrun (ev_data_underrun),
  .ev_len_underrun  (ev_len_underrun),
  .ev_flush_done    (ev_flush_done),
  .flush_pending    (flush_pending),
  .in_pkt           (in_pkt),
  .level            (level),
  .committed        (committed)
);

// File: tb/rx_pkt_ctrl_bench.sv
module rx_pkt_ctrl_bench;
  localparam int DEPTH = 32;
  localparam int MQ    = 4;
  localparam int PF    = 28;
  localparam int PE    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, rd_en = 1'b0, flush_req = 1'b0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_keep = '0, s_dest = '0;
  logic [7:0]  rd_addr = '0;
  logic        s_ready;
  logic [31:0] rd_data;
  logic ev_rx_done, ev_data_underrun, ev_over_read, ev_len_underrun;
  logic ev_prog_full, ev_prog_empty, ev_flush_done;

  always #4 clk = ~clk;

  rx_pkt_ctrl #(.DEPTH(DEPTH), .META_DEPTH(MQ), .PF_THRESH(PF), .PE_THRESH(PE)) u_rx_pkt_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_keep(s_keep), .s_dest(s_dest), .s_last(s_last), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .flush_req(flush_req), .ev_rx_done(ev_rx_done),
    .ev_data_underrun(ev_data_underrun), .ev_over_read(ev_over_read),
    .ev_len_underrun(ev_len_underrun), .ev_prog_full(ev_prog_full),
    .ev_prog_empty(ev_prog_empty), .ev_flush_done(ev_flush_done)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_store[$];
  int m_mb[$], m_md[$], m_mw[$];
  int m_comm = 0, m_left = 0, m_dest = 0, m_acc_b = 0, m_acc_w = 0;
  bit m_inpkt = 0, m_pend = 0;
  logic [31:0] e_rd = '0;
  bit e_done = 0, e_und = 0, e_over = 0, e_lund = 0, e_pf = 0, e_pe = 0, e_fl = 0;
  string rd_tag = "R12";

  int n_vec = 0, n_bad = 0, cycles = 0;
  bit chk_on = 0;

  function automatic bit m_ready();
    return (m_store.size() < DEPTH) && (m_mb.size() < MQ) && !(m_pend && !m_inpkt);
  endfunction

  function automatic int ones(input logic [3:0] k);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(k[i]);
    return n;
  endfunction

  always @(posedge clk) begin
    int old_lvl, new_lvl;
    bit rdy;
    cycles++;
    if (!rst_n) begin
      m_store.delete(); m_mb.delete(); m_md.delete(); m_mw.delete();
      m_comm = 0; m_left = 0; m_dest = 0; m_acc_b = 0; m_acc_w = 0;
      m_inpkt = 0; m_pend = 0; e_rd = '0;
      {e_done, e_und, e_over, e_lund, e_pf, e_pe, e_fl} = '0;
      rd_tag = "R12";
    end else begin
      old_lvl = m_store.size();
      rdy = m_ready();
      {e_done, e_und, e_over, e_lund, e_fl} = '0;
      e_rd = '0;
      rd_tag = "R12";
      if (m_pend && !m_inpkt) begin
        m_store.delete(); m_mb.delete(); m_md.delete(); m_mw.delete();
        m_comm = 0; m_left = 0; m_dest = 0; m_acc_b = 0; m_acc_w = 0;
        m_pend = 0; e_fl = 1;
        if (rd_en) rd_tag = "R10";
      end else begin
        if (flush_req) m_pend = 1;
        if (rd_en) begin
          case (rd_addr)
            8'h1C: begin rd_tag = "R1"; e_rd = 32'(m_comm); end
            8'h20: begin
              rd_tag = "R2";
              if (m_comm == 0) e_und = 1;
              else begin
                e_rd = m_store.pop_front();
                m_comm--;
                if (m_left == 0) e_over = 1; else m_left--;
              end
            end
            8'h24: begin
              rd_tag = "R3";
              if (m_mb.size() == 0) e_lund = 1;
              else begin
                e_rd = 32'(m_mb.pop_front());
                m_dest = m_md.pop_front();
                m_left = m_mw.pop_front();
              end
            end
            8'h30: begin rd_tag = "R4"; e_rd = 32'(m_dest); end
            default: rd_tag = "R12";
          endcase
        end
        if (s_valid && rdy) begin
          m_store.push_back(s_data);
          m_acc_b += ones(s_keep);
          m_acc_w++;
          if (s_last) begin
            m_mb.push_back(m_acc_b); m_md.push_back(int'(s_dest)); m_mw.push_back(m_acc_w);
            m_comm += m_acc_w;
            m_acc_b = 0; m_acc_w = 0; m_inpkt = 0; e_done = 1;
          end else m_inpkt = 1;
        end
      end
      new_lvl = m_store.size();
      e_pf = (new_lvl >= PF) && (old_lvl < PF);
      e_pe = (new_lvl <= PE) && (old_lvl > PE);
    end
  end

  task automatic cmp(input string tag, input string name, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      n_vec++;
      cmp("R9",  "s_ready",          32'(s_ready),          32'(m_ready()));
      cmp(rd_tag, "rd_data",         rd_data,               e_rd);
      cmp("R5",  "ev_rx_done",       32'(ev_rx_done),       32'(e_done));
      cmp("R6",  "ev_data_underrun", 32'(ev_data_underrun), 32'(e_und));
      cmp("R7",  "ev_over_read",     32'(ev_over_read),     32'(e_over));
      cmp("R8",  "ev_len_underrun",  32'(ev_len_underrun),  32'(e_lund));
      cmp("R11", "ev_prog_full",     32'(ev_prog_full),     32'(e_pf));
      cmp("R11", "ev_prog_empty",    32'(ev_prog_empty),    32'(e_pe));
      cmp("R10", "ev_flush_done",    32'(ev_flush_done),    32'(e_fl));
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not end");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic v, input logic [31:0] d, input logic [3:0] k,
                       input logic [3:0] dst, input logic l, input logic re,
                       input logic [7:0] a, input logic fr);
    @(negedge clk);
    s_valid = v; s_data = d; s_keep = k; s_dest = dst; s_last = l;
    rd_en = re; rd_addr = a; flush_req = fr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, '0, 0, 0, '0, 0);
  endtask
  task automatic beat(input logic [31:0] d, input logic [3:0] k, input logic [3:0] dst, input logic l);
    drive(1, d, k, dst, l, 0, '0, 0);
  endtask
  task automatic rd(input logic [7:0] a);
    drive(0, '0, '0, '0, 0, 1, a, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    chk_on = 1;                       // reset state checked here
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    rd(8'h1C);                        // R1: empty count
    rd(8'h24);                        // R8: length underrun
    rd(8'h20);                        // R6: data underrun
    rd(8'h04);                        // R12: unused address
    rd(8'h30);                        // R4: dest after reset
    // packet A: 10 bytes, dest 5; count read mid-packet (R1)
    beat(32'h1111_1111, 4'hF, 4'h5, 0);
    drive(1, 32'h2222_2222, 4'hF, 4'h5, 0, 1, 8'h1C, 0);
    beat(32'h3333_3333, 4'h3, 4'h5, 1);
    rd(8'h1C); rd(8'h24); rd(8'h30);  // R1 R3 R4
    rd(8'h20); rd(8'h20); rd(8'h20);  // R2
    idle(1);
    // packet B (1 byte, dest 2) and C (8 bytes, dest 7)
    beat(32'hB0B0_B0B0, 4'h1, 4'h2, 1);
    beat(32'hC1C1_C1C1, 4'hF, 4'h7, 0);
    beat(32'hC2C2_C2C2, 4'hF, 4'h7, 1);
    rd(8'h24); rd(8'h20);
    rd(8'h20);                        // R7: over-read takes C's first word
    rd(8'h24); rd(8'h30); rd(8'h20);
    rd(8'h20);                        // R6: nothing committed
    // deferred flush during a packet (R10)
    beat(32'hF1F1_F1F1, 4'hF, 4'h9, 0);
    drive(1, 32'hF2F2_F2F2, 4'hF, 4'h9, 0, 0, '0, 1);
    idle(2);
    beat(32'hF3F3_F3F3, 4'hF, 4'h9, 1);
    drive(0, '0, '0, '0, 0, 1, 8'h1C, 0);  // read in the flush cycle
    idle(1);
    rd(8'h1C); rd(8'h24); rd(8'h30);
    // record queue full (R9)
    for (int i = 0; i < MQ + 1; i++) beat(32'hA000_0000 + 32'(i), 4'h7, 4'(i), 1);
    idle(1);
    for (int i = 0; i < MQ; i++) begin rd(8'h24); rd(8'h30); rd(8'h20); end
    // fill to the top (R9, R11)
    for (int i = 0; i < DEPTH; i++) beat(32'h5000_0000 + 32'(i), 4'hF, 4'h3, (i == DEPTH - 1));
    beat(32'hDEAD_BEEF, 4'hF, 4'h3, 1);    // refused while full
    rd(8'h1C); rd(8'h24);
    for (int i = 0; i < DEPTH; i++) rd(8'h20);
    rd(8'h20);
    // flush while idle
    drive(0, '0, '0, '0, 0, 0, '0, 1);
    idle(3);
    rd(8'h1C);
    idle(2);
    finish_run();
  end

endmodule